// File: doc/BRIEF.md
# Segmented Address Widening Translator

This unit turns a 32-bit logical address into a 36-bit physical address. Sixteen segment descriptors are held in registers. Each descriptor carries a logical page base, a physical page base, a power-of-two size and an enable bit. A translation compares the incoming address against every descriptor at the same time. The matching descriptor with the highest index supplies the upper physical bits. The low bits inside the segment come straight from the logical address.

Descriptors are written one at a time through a single 64-bit write port, addressed by descriptor index. The translate path has no clock. The physical address, a hit flag and the index of the winning descriptor follow the logical input within the same cycle. After reset, two descriptors are already enabled. The lower half of the logical space then maps one-to-one onto physical space. The upper half maps onto the range that starts at physical 0x8_0000_0000.

Top module: `addr_ext_unit`

## Requirements
- R1: After reset, descriptor 0 is enabled with 2 GB size. It maps logical 0x0000_0000..0x7FFF_FFFF one-to-one onto physical 0x0_0000_0000..0x0_7FFF_FFFF and reports index 0.
- R2: After reset, descriptor 1 is enabled with 2 GB size. It maps logical 0x8000_0000..0xFFFF_FFFF onto physical 0x8_0000_0000..0x8_7FFF_FFFF and reports index 1.
- R3: After reset, descriptors 2..15 are disabled. Once descriptor 0 is disabled, a low-half address misses.
- R4: A descriptor write word is laid out as follows. Bits 19:0 hold the logical page base (address bits 31:12). Bits 43:20 hold the physical page base (address bits 35:12). Bits 48:44 hold the size code. Bit 63 is the enable. Bits 62:49 are ignored.
- R5: A size code c gives a segment of 2^(12+c) bytes. Codes 20 and above give 4 GB. Base bits below the segment size are ignored, so segments are aligned to their size.
- R6: When several enabled descriptors match, the one with the highest index wins and is reported on hit_idx_o.
- R7: When no enabled descriptor matches, hit_o is 0, pa_o is zero and hit_idx_o is zero.
- R8: On a hit, pa_o equals the aligned physical base plus the offset of la_i from the aligned logical base. Bits 11:0 pass through unchanged.
- R9: Translation is combinational from la_i. A descriptor write takes effect at the clock edge that samples it and not before.
- R10: A disabled descriptor never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_idx_i | input | 4 | Index of descriptor to write |
| wr_data_i | input | 64 | Descriptor write word |
| la_i | input | 32 | Logical address |
| pa_o | output | 36 | Physical address, zero on miss |
| hit_o | output | 1 | A descriptor matched |
| hit_idx_o | output | 4 | Index of winning descriptor, zero on miss |

## Verification
The hardest cases to reach are overlapping segments of different sizes and a write that lands while the affected address is being translated. Random addresses seldom fall inside a small segment. To reach them, the stimulus programs nested segments on purpose (4 KB, 64 KB and 4 GB over the default halves) and samples the outputs just before and just after a write edge. In the random phase, half of the addresses are steered onto the page base of a randomly chosen programmed descriptor. Random size codes drive frequent partial overlaps and out-of-range size codes.

// File: rtl/aeu_pkg.sv
package aeu_pkg;
  localparam int unsigned LA_W   = 32;
  localparam int unsigned PA_W   = 36;
  localparam int unsigned PG_W   = 12;
  localparam int unsigned LPN_W  = LA_W - PG_W;
  localparam int unsigned PPN_W  = PA_W - PG_W;
  localparam int unsigned SZ_W   = 5;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned MAX_SZ = LPN_W;  // 4 GB

  typedef struct packed {
    logic             en;
    logic [SZ_W-1:0]  sz;
    logic [PPN_W-1:0] ppn;
    logic [LPN_W-1:0] lpn;
  } desc_t;

  function automatic desc_t word_to_desc(input logic [WORD_W-1:0] w);
    desc_t d;
    d.en  = w[63];
    d.sz  = w[48:44];
    d.ppn = w[43:20];
    d.lpn = w[19:0];
    return d;
  endfunction

  function automatic desc_t reset_desc(input int unsigned idx);
    desc_t d;
    d = '0;
    if (idx == 0) begin
      d.en = 1'b1;
      d.sz = SZ_W'(19);
    end else if (idx == 1) begin
      d.en  = 1'b1;
      d.sz  = SZ_W'(19);
      d.ppn = PPN_W'(24'h80_0000);
      d.lpn = LPN_W'(20'h8_0000);
    end
    return d;
  endfunction
endpackage

// File: rtl/aeu_desc_regs.sv
module aeu_desc_regs
  import aeu_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [WORD_W-1:0]          wr_data_i,
  output desc_t [NUM_SEG-1:0]        desc_o
);
  desc_t wr_desc;
  logic  unused_rsvd;

  assign wr_desc     = word_to_desc(wr_data_i);
  assign unused_rsvd = ^wr_data_i[62:49];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_desc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        desc_o[i] <= reset_desc(i);
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        desc_o[i] <= wr_desc;
      end
    end
  end
endmodule

// File: rtl/aeu_seg_match.sv
module aeu_seg_match
  import aeu_pkg::*;
(
  input  desc_t             desc_i,
  input  logic [LPN_W-1:0]  lpn_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o
);
  logic [SZ_W-1:0]  sz_clamped;
  logic [LPN_W-1:0] cmp_mask;  // 1 = page bit compared against base

  assign sz_clamped = (desc_i.sz > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : desc_i.sz;

  always_comb begin
    for (int b = 0; b < LPN_W; b++) begin
      cmp_mask[b] = (b >= int'(sz_clamped));
    end
  end

  assign hit_o = desc_i.en && (((lpn_i ^ desc_i.lpn) & cmp_mask) == '0);
  assign ppn_o = {desc_i.ppn[PPN_W-1:LPN_W],
                  (desc_i.ppn[LPN_W-1:0] & cmp_mask) | (lpn_i & ~cmp_mask)};
endmodule

// File: rtl/aeu_prio_select.sv
module aeu_prio_select
  import aeu_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0]             hit_i,
  input  logic [NUM_SEG-1:0][PPN_W-1:0]  ppn_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [PPN_W-1:0]               ppn_o
);
  // later entries overwrite earlier ones: highest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    ppn_o = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (hit_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        ppn_o = ppn_i[i];
      end
    end
  end
endmodule

// File: rtl/addr_ext_unit.sv
module addr_ext_unit
  import aeu_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [$clog2(NUM_SEG)-1:0]  wr_idx_i,
  input  logic [63:0]                 wr_data_i,
  input  logic [31:0]                 la_i,
  output logic [35:0]                 pa_o,
  output logic                        hit_o,
  output logic [$clog2(NUM_SEG)-1:0]  hit_idx_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SEG);

  desc_t [NUM_SEG-1:0]            desc;
  logic  [NUM_SEG-1:0]            seg_hit;
  logic  [NUM_SEG-1:0][PPN_W-1:0] seg_ppn;
  logic  [PPN_W-1:0]              win_ppn;
  logic                           any_hit;
  logic  [IDX_W-1:0]              win_idx;

  aeu_desc_regs #(.NUM_SEG(NUM_SEG)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .desc_o    (desc)
  );

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_match
    aeu_seg_match u_match (
      .desc_i (desc[i]),
      .lpn_i  (la_i[LA_W-1:PG_W]),
      .hit_o  (seg_hit[i]),
      .ppn_o  (seg_ppn[i])
    );
  end

  aeu_prio_select #(.NUM_SEG(NUM_SEG)) u_prio (
    .hit_i (seg_hit),
    .ppn_i (seg_ppn),
    .hit_o (any_hit),
    .idx_o (win_idx),
    .ppn_o (win_ppn)
  );

  assign hit_o     = any_hit;
  assign hit_idx_o = win_idx;
  assign pa_o      = any_hit ? {win_ppn, la_i[PG_W-1:0]} : '0;
endmodule

// File: rtl/aeu_checker.sv
module aeu_checker #(
  parameter int unsigned NUM_SEG = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic [$clog2(NUM_SEG)-1:0]  wr_idx_i,
  input logic [63:0]                 wr_data_i,
  input logic [31:0]                 la_i,
  input logic [35:0]                 pa_o,
  input logic                        hit_o,
  input logic [$clog2(NUM_SEG)-1:0]  hit_idx_o
);
  a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0 && hit_idx_o == '0));

  a_r8_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[11:0] == la_i[11:0]));

  a_r10_disabled_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[63]) |=> !(hit_o && hit_idx_o == $past(wr_idx_i)));

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $stable(la_i)) |-> ($stable(pa_o) && $stable(hit_o)));
endmodule

bind addr_ext_unit aeu_checker #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .la_i      (la_i),
  .pa_o      (pa_o),
  .hit_o     (hit_o),
  .hit_idx_o (hit_idx_o)
);

// File: tb/addr_ext_unit_tb.sv
`timescale 1ns/1ps
module addr_ext_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic [31:0] la;
  logic [35:0] pa;
  logic        hit;
  logic [3:0]  hit_idx;

  logic [63:0] mdl [16];
  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  addr_ext_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .la_i(la), .pa_o(pa), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  function automatic logic [63:0] mk(bit en, logic [4:0] sz, logic [23:0] ppn, logic [19:0] lpn);
    return {en, 14'h0, sz, ppn, lpn};
  endfunction

  // reference model: range compare on 64-bit integers
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) mdl[i] <= '0;
      mdl[0] <= mk(1'b1, 5'd19, 24'h0, 20'h0);
      mdl[1] <= mk(1'b1, 5'd19, 24'h80_0000, 20'h8_0000);
    end else if (wr_en) begin
      mdl[wr_idx] <= wr_data;
    end
  end

  task automatic model(input logic [31:0] a, output bit h, output int idx, output logic [35:0] p);
    h = 0; idx = 0; p = '0;
    for (int i = 0; i < 16; i++) begin
      int unsigned code;
      logic [63:0] size, base, pbase, a64;
      code  = mdl[i][48:44];
      if (code > 20) code = 20;
      size  = 64'd1 << (12 + code);
      base  = {32'h0, mdl[i][19:0], 12'h0} & ~(size - 1);
      pbase = {28'h0, mdl[i][43:20], 12'h0} & ~(size - 1);
      a64   = {32'h0, a};
      if (mdl[i][63] && a64 >= base && a64 < base + size) begin
        h = 1; idx = i;
        p = 36'(pbase + (a64 - base));
      end
    end
  endtask

  task automatic chk_exp(string tag, bit eh, int ei, logic [35:0] ep);
    checks++;
    if (hit !== eh || pa !== ep || int'(hit_idx) != ei) begin
      errors++;
      $display("FAIL %s: la=%h got hit=%0b idx=%0d pa=%h, expected hit=%0b idx=%0d pa=%h",
               tag, la, hit, hit_idx, pa, eh, ei, ep);
    end
  endtask

  task automatic chk_model(string tag);
    bit h; int i; logic [35:0] p;
    model(la, h, i, p);
    chk_exp(tag, h, i, p);
  endtask

  always @(negedge clk) if (cmp_en && rst_ni) chk_model("R8 model");

  task automatic set_la(logic [31:0] a);
    la = a;
    #1;
  endtask

  task automatic write(logic [3:0] idx, logic [63:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; la = '0;
    #21;
    chk_exp("R1 reset", 1, 0, 36'h0_0000_0000);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    set_la(32'h1234_5678); chk_exp("R1", 1, 0, 36'h0_1234_5678);
    set_la(32'h7FFF_FFFF); chk_exp("R1 top", 1, 0, 36'h0_7FFF_FFFF);
    set_la(32'hDEAD_BEEF); chk_exp("R2", 1, 1, 36'h8_5EAD_BEEF);
    set_la(32'h8000_0000); chk_exp("R2 base", 1, 1, 36'h8_0000_0000);
    // disable descriptor 0: nothing else covers the low half
    write(4'd0, mk(1'b0, 5'd19, 24'h0, 20'h0));
    set_la(32'h0000_1000); chk_exp("R3", 0, 0, 36'h0);
    set_la(32'h5555_0123); chk_exp("R7 miss", 0, 0, 36'h0);
    // disabled entry with matching base
    write(4'd3, mk(1'b0, 5'd0, 24'hABCDE, 20'h00001));
    set_la(32'h0000_1000); chk_exp("R10", 0, 0, 36'h0);
    // field layout, 4 KB page, reserved bits set
    write(4'd5, mk(1'b1, 5'd0, 24'h0ABCDE, 20'h12345) | 64'h7FFE_0000_0000_0000);
    set_la(32'h1234_5ABC); chk_exp("R4", 1, 5, 36'h0_ABCD_EABC);
    set_la(32'h1234_6ABC); chk_exp("R4 edge", 0, 0, 36'h0);
    // 64 KB, unaligned bases
    write(4'd7, mk(1'b1, 5'd4, 24'h030005, 20'h40003));
    set_la(32'h4000_F123); chk_exp("R5 64K", 1, 7, 36'h0_3000_F123);
    chk_exp("R8 offset", 1, 7, 36'h0_3000_F123);
    set_la(32'h4001_0000); chk_exp("R5 outside", 0, 0, 36'h0);
    // out-of-range code -> 4 GB
    write(4'd6, mk(1'b1, 5'd31, 24'hF0_0000, 20'h12345));
    set_la(32'h0000_1000); chk_exp("R5 4G", 1, 6, 36'hF_0000_1000);
    set_la(32'h4000_F123); chk_exp("R6 higher", 1, 7, 36'h0_3000_F123);
    set_la(32'h9000_0000); chk_exp("R6 over seg1", 1, 6, 36'hF_9000_0000);
    // write timing
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = 4'd6; wr_data = mk(1'b0, 5'd31, 24'hF0_0000, 20'h0);
    #1; chk_exp("R9 before edge", 1, 6, 36'hF_9000_0000);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk_exp("R9 after edge", 1, 1, 36'h8_1000_0000);
    set_la(32'h0000_2000); chk_exp("R9 comb", 0, 0, 36'h0);
    // random phase with per-clock model comparison
    cmp_en = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      wr_en   = ($urandom % 6) == 0;
      wr_idx  = 4'($urandom);
      wr_data = {$urandom, $urandom};
      if ($urandom % 2) la = {mdl[$urandom % 16][19:0], 12'($urandom)};
      else              la = $urandom;
    end
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk); cmp_en = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule